// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the memory operand address for 32-bit addressing of the form displacement + base + index × scale. The address decoder ahead of it supplies the register numbers, the scale code, the displacement and an optional segment override. The eight general register values arrive as one flattened bus. One cycle after a valid strobe, the block returns the 32-bit effective address. It also returns the segment that the access should use by default, or the override if one was given, and a flag that marks an illegal operand form.

The default segment depends only on the base register. The stack and frame pointers as base select the stack segment. Every other case selects the data segment, including an access with no base at all and an access that uses the frame pointer as index. The stack pointer cannot serve as the index register, and asking for it raises the illegal flag. Parsing instruction bytes, checking limits and translating linear addresses are handled by other blocks.

Top module: `sia_ea_gen`

## Requirements
- R1: One cycle after a strobe, out_addr equals disp + base value + (index value << scale_code), truncated to 32 bits so that overflow wraps. The scale codes 0, 1, 2 and 3 mean factors of 1, 2, 4 and 8.
- R2: An absent base (base_en=0) or an absent index (idx_en=0) adds zero to the sum. With both absent, out_addr equals disp.
- R3: Any of the eight registers may serve as the base. Register n is held in gpr_flat[32n+31:32n].
- R4: out_illegal is 1 when the index is present and idx_sel is 4, the stack pointer. In every other case it is 0.
- R5: With no override, out_seg is SS (code 2) when the base is present and base_sel is 4 or 5. Otherwise it is DS (code 3), and the index register never affects it.
- R6: With no base present and no override, out_seg is DS (code 3).
- R7: With ovr_en=1, out_seg equals ovr_seg. The segment codes are ES=0, CS=1, SS=2, DS=3, FS=4 and GS=5.
- R8: out_vld is 1 in exactly the cycle after a cycle in which in_vld was 1. A new result is taken only on a strobe.
- R9: While rst_n is low, out_vld=0, out_addr=0, out_illegal=0 and out_seg=DS (code 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Request strobe |
| base_en | input | 1 | Base register present |
| base_sel | input | 3 | Base register number |
| idx_en | input | 1 | Index register present |
| idx_sel | input | 3 | Index register number |
| scale_code | input | 2 | Index shift amount (factor 1/2/4/8) |
| disp | input | 32 | Displacement |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 3 | Override segment code |
| gpr_flat | input | 256 | Eight register values, register n at bits 32n+31:32n |
| out_vld | output | 1 | Result valid |
| out_addr | output | 32 | Effective address |
| out_seg | output | 3 | Selected segment code |
| out_illegal | output | 1 | Stack pointer requested as index |

## Verification
A wrong register selection or shift in this block shows up as a wrong out_addr in the cycle right after the strobe. A wrong base decode shows up at the same time as a wrong out_seg. There is no internal state other than the output register, so every fault appears within one cycle of the request that triggers it. A sweep that covers every base and index combination at every scale therefore exposes any corrupted mux leg, shift or segment decode after a single strobe.

// File: rtl/sia_pkg.sv
package sia_pkg;
   localparam int SEG_W = 3;
   typedef enum logic [SEG_W-1:0] {
      SEG_ES = 3'd0,
      SEG_CS = 3'd1,
      SEG_SS = 3'd2,
      SEG_DS = 3'd3,
      SEG_FS = 3'd4,
      SEG_GS = 3'd5
   } seg_e;
   localparam int SCALE_W = 2;
endpackage

// File: rtl/sia_regpick.sv
module sia_regpick #(
   parameter int AW   = 32,
   parameter int NREG = 8,
   localparam int RSEL = $clog2(NREG)
) (
   input  logic [NREG*AW-1:0] regs,
   input  logic               en,
   input  logic [RSEL-1:0]    sel,
   output logic [AW-1:0]      val
);
   logic [AW-1:0] lane [NREG];
   for (genvar g = 0; g < NREG; g++) begin : g_lane
      assign lane[g] = regs[g*AW +: AW];
   end
   always_comb begin
      val = '0;
      if (en) val = lane[sel];
   end
endmodule

// File: rtl/sia_scaler.sv
module sia_scaler #(
   parameter int AW        = 32,
   parameter bit USE_SHIFT = 1'b1
) (
   input  logic [AW-1:0]               idx,
   input  logic [sia_pkg::SCALE_W-1:0] code,
   output logic [AW-1:0]               scaled
);
   if (USE_SHIFT) begin : g_shift
      assign scaled = idx << code;
   end else begin : g_mux
      always_comb begin
         unique case (code)
            2'd0:    scaled = idx;
            2'd1:    scaled = {idx[AW-2:0], 1'b0};
            2'd2:    scaled = {idx[AW-3:0], 2'b0};
            default: scaled = {idx[AW-4:0], 3'b0};
         endcase
      end
   end
endmodule

// File: rtl/sia_segsel.sv
module sia_segsel #(
   parameter int NREG    = 8,
   parameter int SP_NUM  = 4,
   parameter int FP_NUM  = 5,
   parameter bit HAS_OVR = 1'b1,
   localparam int RSEL = $clog2(NREG)
) (
   input  logic                      base_en,
   input  logic [RSEL-1:0]           base_sel,
   input  logic                      ovr_en,
   input  logic [sia_pkg::SEG_W-1:0] ovr_seg,
   output logic [sia_pkg::SEG_W-1:0] seg
);
   import sia_pkg::*;
   logic stack_base;
   logic [SEG_W-1:0] dflt;
   assign stack_base = base_en &&
      ((base_sel == RSEL'(SP_NUM)) || (base_sel == RSEL'(FP_NUM)));
   assign dflt = stack_base ? SEG_SS : SEG_DS;
   if (HAS_OVR) begin : g_ovr
      assign seg = ovr_en ? ovr_seg : dflt;
   end else begin : g_noovr
      logic unused_ovr;
      assign unused_ovr = ovr_en ^ (^ovr_seg);
      assign seg = dflt;
   end
endmodule

// File: rtl/sia_ea_gen.sv
module sia_ea_gen #(
   parameter int AW        = 32,
   parameter int NREG      = 8,
   parameter int SP_NUM    = 4,
   parameter int FP_NUM    = 5,
   parameter bit USE_SHIFT = 1'b1,
   parameter bit HAS_OVR   = 1'b1,
   localparam int RSEL = $clog2(NREG)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_vld,
   input  logic                      base_en,
   input  logic [RSEL-1:0]           base_sel,
   input  logic                      idx_en,
   input  logic [RSEL-1:0]           idx_sel,
   input  logic [1:0]                scale_code,
   input  logic [AW-1:0]             disp,
   input  logic                      ovr_en,
   input  logic [sia_pkg::SEG_W-1:0] ovr_seg,
   input  logic [NREG*AW-1:0]        gpr_flat,
   output logic                      out_vld,
   output logic [AW-1:0]             out_addr,
   output logic [sia_pkg::SEG_W-1:0] out_seg,
   output logic                      out_illegal
);
   import sia_pkg::*;

   if (NREG != (1 << RSEL)) begin : g_bad_nreg
      $error("NREG must be a power of two");
   end
   if (SP_NUM >= NREG || FP_NUM >= NREG) begin : g_bad_num
      $error("stack/frame register number out of range");
   end
   if (AW < 8) begin : g_bad_aw
      $error("AW too small");
   end

   logic [AW-1:0]    base_v, idx_v, idx_s, sum;
   logic [SEG_W-1:0] seg_c;
   logic             bad_c;

   sia_regpick #(.AW(AW), .NREG(NREG)) u_base (
      .regs(gpr_flat), .en(base_en), .sel(base_sel), .val(base_v));
   sia_regpick #(.AW(AW), .NREG(NREG)) u_idx (
      .regs(gpr_flat), .en(idx_en), .sel(idx_sel), .val(idx_v));
   sia_scaler #(.AW(AW), .USE_SHIFT(USE_SHIFT)) u_scale (
      .idx(idx_v), .code(scale_code), .scaled(idx_s));
   sia_segsel #(.NREG(NREG), .SP_NUM(SP_NUM), .FP_NUM(FP_NUM),
                .HAS_OVR(HAS_OVR)) u_seg (
      .base_en(base_en), .base_sel(base_sel), .ovr_en(ovr_en),
      .ovr_seg(ovr_seg), .seg(seg_c));

   assign sum   = disp + base_v + idx_s;
   assign bad_c = idx_en && (idx_sel == RSEL'(SP_NUM));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld     <= 1'b0;
         out_addr    <= '0;
         out_seg     <= SEG_DS;
         out_illegal <= 1'b0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_addr    <= sum;
            out_seg     <= seg_c;
            out_illegal <= bad_c;
         end
      end
   end

   // R8: strobe to result latency
   assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);
   assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);
   // R4: stack pointer as index is flagged
   assert_sp_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && idx_en && idx_sel == RSEL'(SP_NUM)) |=> out_illegal);
   // R2: no registers means address is the displacement
   assert_disp_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !base_en && !idx_en) |=> (out_addr == $past(disp)));
   // R5: stack-pointer base defaults to SS
   assert_stack_seg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !ovr_en && base_en && base_sel == RSEL'(SP_NUM))
      |=> (out_seg == SEG_SS));
   // R6: no base defaults to DS
   assert_nobase_seg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !ovr_en && !base_en) |=> (out_seg == SEG_DS));
   // R7: override wins
   assert_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && ovr_en) |=> (out_seg == $past(ovr_seg)));
   // R8: held result is stable without a strobe
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(out_addr));
endmodule

// File: tb/tb_sia_ea_gen.sv
module tb_sia_ea_gen;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_vld, base_en, idx_en, ovr_en;
   logic [2:0]  base_sel, idx_sel, ovr_seg;
   logic [1:0]  scale_code;
   logic [31:0] disp;
   logic [255:0] gpr_flat;
   logic        out_vld, out_illegal;
   logic [31:0] out_addr;
   logic [2:0]  out_seg;
   logic [31:0] regs [8];
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   always_comb
      for (int i = 0; i < 8; i++) gpr_flat[i*32 +: 32] = regs[i];

   sia_ea_gen dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .base_en(base_en),
      .base_sel(base_sel), .idx_en(idx_en), .idx_sel(idx_sel),
      .scale_code(scale_code), .disp(disp), .ovr_en(ovr_en),
      .ovr_seg(ovr_seg), .gpr_flat(gpr_flat), .out_vld(out_vld),
      .out_addr(out_addr), .out_seg(out_seg), .out_illegal(out_illegal));

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input bit be, input int bs, input bit ie, input int is,
                      input int sc, input logic [31:0] d,
                      input bit oe, input int os, input string req);
      logic [31:0] ea;
      logic [2:0]  es;
      @(negedge clk);
      in_vld = 1'b1; base_en = be; base_sel = 3'(bs); idx_en = ie;
      idx_sel = 3'(is); scale_code = 2'(sc); disp = d; ovr_en = oe;
      ovr_seg = 3'(os);
      ea = d + (be ? regs[bs] : 32'd0) + (ie ? regs[is] * (32'd1 << sc) : 32'd0);
      if (oe) es = 3'(os);
      else if (be && (bs == 4 || bs == 5)) es = 3'd2;
      else es = 3'd3;
      @(negedge clk);
      in_vld = 1'b0;
      chk({req, "/R8 vld"}, {31'd0, out_vld}, 32'd1);
      chk({req, "/R1 addr"}, out_addr, ea);
      chk({req, "/R5 seg"}, {29'd0, out_seg}, {29'd0, es});
      chk({req, "/R4 illegal"}, {31'd0, out_illegal},
          {31'd0, (ie && is == 4)});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_vld = 0; base_en = 0; idx_en = 0; ovr_en = 0;
      base_sel = 0; idx_sel = 0; scale_code = 0; disp = 0; ovr_seg = 0;
      for (int i = 0; i < 8; i++)
         regs[i] = (32'(i) * 32'h2468_ACE1) ^ 32'hA5A5_0000;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 vld", {31'd0, out_vld}, 32'd0);
      chk("R9 addr", out_addr, 32'd0);
      chk("R9 illegal", {31'd0, out_illegal}, 32'd0);
      chk("R9 seg", {29'd0, out_seg}, 32'd3);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 idle", {31'd0, out_vld}, 32'd0);

      // R1 R3 R4 R5: full sweep of base, index and scale
      for (int be = 0; be < 2; be++)
         for (int bs = 0; bs < 8; bs++)
            for (int ie = 0; ie < 2; ie++)
               for (int is = 0; is < 8; is++)
                  for (int sc = 0; sc < 4; sc++)
                     run(be[0], bs, ie[0], is, sc, 32'h0000_0100 * 32'(sc + 1),
                         1'b0, 0, "R1 R3 sweep");

      // R2 R6: displacement only, including wrap values
      run(0, 3, 0, 6, 2, 32'hFFFF_FFF0, 0, 0, "R2 R6 disp-only");
      run(0, 5, 0, 5, 3, 32'h0000_0000, 0, 0, "R2 R6 zero");
      // R6: index only, frame pointer as index stays DS
      run(0, 0, 1, 5, 1, 32'h10, 0, 0, "R6 R5 idx-fp");

      // R7: every override value with a stack base
      for (int os = 0; os < 6; os++)
         run(1, 4, 1, 2, 0, 32'h44, 1, os, "R7 override");

      // R8: no strobe leaves out_vld low and address held
      @(negedge clk);
      chk("R8 no strobe vld", {31'd0, out_vld}, 32'd0);

      // R1: worked examples and wrap
      regs[3] = 32'h1000; regs[6] = 32'h4;
      run(1, 3, 1, 6, 2, 32'h8, 0, 0, "R1 ex1");
      chk("R1 ex1 literal", out_addr, 32'h1018);
      regs[6] = 32'h1000;
      run(1, 3, 1, 3, 1, 32'h1000, 0, 0, "R1 ex2");
      chk("R1 ex2 literal", out_addr, 32'h4000);
      regs[0] = 32'hFFFF_FFFF; regs[1] = 32'h8000_0000;
      run(1, 0, 1, 1, 3, 32'h2, 0, 0, "R1 wrap");
      chk("R1 wrap literal", out_addr, 32'h0000_0001);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule